// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in an audio output sample path and scales each stereo frame by a gain that follows a mute request. When mute is requested the gain falls in equal steps from unity to zero, one step per output frame, so full silence is reached after a fixed number of frames (1024 by default). When the request is dropped, the gain climbs back to unity at the same rate. If the request is dropped partway down, the gain turns around from the level it has reached and does not jump or restart.

Samples arrive as signed left/right words with a one-cycle frame strobe. Each strobe produces one scaled frame on the output one clock later, together with its own strobe. A status flag is high while the gain stands at zero. The gain moves only on frame strobes, so the ramp length is counted in frames, whatever the system clock rate.

Top module: `soft_mute_ramp`

## Requirements
- R1: After synchronous reset the gain is unity (1024), `muted` is 0, `out_valid` is 0 and both outputs are 0.
- R2: `out_valid` is high for exactly the one cycle after each cycle with `in_valid` high, and the outputs change only on those cycles.
- R3: Each output sample equals the input sample times g/1024, rounded toward zero, where g is the gain held before that frame's strobe; at g = 1024 the sample passes unchanged.
- R4: With `mute_req` high at a strobe and g > 0, g drops by 1; starting from unity it reaches 0 after 1024 strobes and then stays there.
- R5: With `mute_req` low at a strobe and g < 1024, g rises by 1; starting from 0 it reaches 1024 after 1024 strobes and then stays there.
- R6: Dropping `mute_req` in mid-ramp makes the gain climb from its current value; after as many frames as it fell, it is back at unity.
- R7: While g = 0, frames come out exactly zero, and `muted` is high exactly when g = 0 (updated in the cycle after the strobe that changes g).
- R8: The gain does not change in cycles without `in_valid`, however many clocks pass.
- R9: Left and right of one frame are scaled by the same gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req | input | 1 | Mute request, sampled on each frame strobe |
| in_valid | input | 1 | One-cycle frame strobe for the input samples |
| in_left | input | 24 | Signed left input sample |
| in_right | input | 24 | Signed right input sample |
| out_valid | output | 1 | One-cycle strobe for the scaled frame |
| out_left | output | 24 | Signed scaled left sample |
| out_right | output | 24 | Signed scaled right sample |
| muted | output | 1 | High while the gain is zero |

## Verification
The assertions take for granted that `in_valid` is a strobe of frames, so a step check compares the gain with its value on the previous strobe cycle, and that `mute_req` is stable around the strobe edge. The stimulus drives every input on the falling clock edge, keeps at least three idle cycles between strobes, and changes `mute_req` only between frames. One long idle stretch with the request changed checks that clocks alone do not move the ramp.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_LEFT = 0;
  localparam int unsigned CH_RIGHT = 1;
endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
  parameter int unsigned RAMP_STEPS = 1024,
  localparam int unsigned CNT_W = $clog2(RAMP_STEPS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             mute_req,
  output logic [CNT_W-1:0] gain_q,
  output logic             zero_q
);
  localparam logic [CNT_W-1:0] G_MAX = CNT_W'(RAMP_STEPS);

  logic [CNT_W-1:0] gain_nx;

  always_comb begin
    gain_nx = gain_q;
    if (mute_req && gain_q != '0)
      gain_nx = gain_q - 1'b1;
    else if (!mute_req && gain_q != G_MAX)
      gain_nx = gain_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= G_MAX;
      zero_q <= 1'b0;
    end else if (step_en) begin
      gain_q <= gain_nx;
      zero_q <= (gain_nx == '0);
    end
  end
endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned RAMP_STEPS = 1024,
  localparam int unsigned SH = $clog2(RAMP_STEPS),
  localparam int unsigned CNT_W = SH + 1,
  localparam int unsigned PW = DATA_W + CNT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [CNT_W-1:0]         gain,
  output logic signed [DATA_W-1:0] result
);
  localparam logic signed [PW-1:0] BIAS = PW'((1 << SH) - 1);

  logic signed [PW-1:0] s_ext, g_ext, prod, adj;
  logic                 unused_bits;

  assign s_ext = PW'(sample);
  assign g_ext = PW'($signed({1'b0, gain}));
  assign prod  = s_ext * g_ext;
  // bias negative products so the shift rounds toward zero
  assign adj   = prod + (prod[PW-1] ? BIAS : '0);
  assign unused_bits = ^{adj[PW-1:SH+DATA_W], adj[SH-1:0]};

  always_ff @(posedge clk) begin
    if (rst)
      result <= '0;
    else if (en)
      result <= adj[SH +: DATA_W];
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned RAMP_STEPS = 1024,
  localparam int unsigned CNT_W = $clog2(RAMP_STEPS) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mute_req,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     muted
);
  import smr_pkg::*;

  logic [CNT_W-1:0]         gain_q;
  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];

  assign ch_in[CH_LEFT]  = in_left;
  assign ch_in[CH_RIGHT] = in_right;
  assign out_left  = ch_out[CH_LEFT];
  assign out_right = ch_out[CH_RIGHT];

  smr_gain_ctrl #(.RAMP_STEPS(RAMP_STEPS)) u_gain (
    .clk      (clk),
    .rst      (rst),
    .step_en  (in_valid),
    .mute_req (mute_req),
    .gain_q   (gain_q),
    .zero_q   (muted)
  );

  // one scaler per channel, all fed by the same gain (R9)
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    smr_scale #(.DATA_W(DATA_W), .RAMP_STEPS(RAMP_STEPS)) u_scale (
      .clk    (clk),
      .rst    (rst),
      .en     (in_valid),
      .sample (ch_in[c]),
      .gain   (gain_q),
      .result (ch_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/smr_chk.sv
module smr_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W = 11,
  parameter int unsigned RAMP_STEPS = 1024
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mute_req,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic                     muted,
  input logic [CNT_W-1:0]         gain
);
  localparam logic [CNT_W-1:0] G_MAX = CNT_W'(RAMP_STEPS);

  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));
  p_unity_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && gain == G_MAX |=> out_left == $past(in_left) && out_right == $past(in_right));
  p_down_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && mute_req && gain != '0 |=> gain == $past(gain) - 1'b1);
  p_up_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && !mute_req && gain != G_MAX |=> gain == $past(gain) + 1'b1);
  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    gain <= G_MAX);
  p_zero_out_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && gain == '0 |=> out_left == '0 && out_right == '0);
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    muted == (gain == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gain));
endmodule

bind soft_mute_ramp smr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RAMP_STEPS(RAMP_STEPS)) u_chk (
  .clk(clk), .rst(rst), .mute_req(mute_req), .in_valid(in_valid),
  .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .muted(muted), .gain(gain_q)
);

// File: tb/sim_soft_mute_ramp.sv
`timescale 1ns/1ps
module sim_soft_mute_ramp;
  localparam int DW = 24;
  localparam int STEPS = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mute_req = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_left = '0, in_right = '0;
  logic out_valid, muted;
  logic signed [DW-1:0] out_left, out_right;

  int errors = 0;
  int checks = 0;
  int gm = STEPS;   // bench model of the gain

  always #2.5 clk = ~clk;

  soft_mute_ramp u0 (
    .clk(clk), .rst(rst), .mute_req(mute_req), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .muted(muted)
  );

  function automatic int scl(input int s, input int g);
    longint p;
    p = longint'(s) * longint'(g);
    return int'(p / STEPS);   // integer division rounds toward zero
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame: strobe, check outputs and flag, then idle cycles
  task automatic frame(input int l, input int r, input string req);
    @(negedge clk);
    in_left = DW'(l); in_right = DW'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R2 out_valid"}, int'(out_valid), 1);
    chk({req, " R3/R9 left"},  int'(out_left),  scl(l, gm));
    chk({req, " R3/R9 right"}, int'(out_right), scl(r, gm));
    if (mute_req && gm > 0) gm--;
    else if (!mute_req && gm < STEPS) gm++;
    chk({req, " R7 muted flag"}, int'(muted), int'(gm == 0));
    @(negedge clk);
    chk({req, " R2 strobe width"}, int'(out_valid), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 muted", int'(muted), 0);
    chk("R1 out_left", int'(out_left), 0);
    chk("R1 out_right", int'(out_right), 0);
  endtask

  task automatic t_unity();
    mute_req = 1'b0;
    frame(8388607, -8388608, "R1 unity");
    frame(-1, 12345, "R3 unity");
    chk("R3 passthrough", int'(out_left), -1);
  endtask

  task automatic t_ramp_down();
    mute_req = 1'b1;
    for (int i = 0; i < STEPS; i++)
      frame(8388607 - i * 37, -3 - (i % 5), "R4 ramp down");
    chk("R4 gain zero after 1024", gm, 0);
    chk("R7 muted high", int'(muted), 1);
    frame(-8388608, 8388607, "R7 zero frame");
    chk("R7 left zero", int'(out_left), 0);
    chk("R7 right zero", int'(out_right), 0);
    chk("R4 stays zero", int'(muted), 1);
  endtask

  task automatic t_idle();
    // request released but no strobes: gain must not move
    @(negedge clk);
    mute_req = 1'b0;
    repeat (600) @(negedge clk);
    chk("R8 muted after idle", int'(muted), 1);
    frame(1000000, -1000000, "R8 first frame after idle");
    chk("R8 still zero output", int'(out_left), 0);
  endtask

  task automatic t_ramp_up();
    mute_req = 1'b0;
    for (int i = 0; i < STEPS - 1; i++)
      frame(-7000000 + i * 11, 5000000, "R5 ramp up");
    chk("R5 unity reached", gm, STEPS);
    frame(4242, -4242, "R5 unity hold");
    chk("R5 passthrough left", int'(out_left), 4242);
    chk("R5 passthrough right", int'(out_right), -4242);
  endtask

  task automatic t_reverse();
    mute_req = 1'b1;
    for (int i = 0; i < 300; i++)
      frame(6000001, -6000001, "R6 partial down");
    chk("R6 mid level", gm, STEPS - 300);
    chk("R6 not muted", int'(muted), 0);
    mute_req = 1'b0;
    for (int i = 0; i < 300; i++)
      frame(6000001, -777, "R6 climb back");
    chk("R6 back at unity", gm, STEPS);
    frame(-999, 999, "R6 unity after reversal");
    chk("R6 exact passthrough", int'(out_left), -999);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unity();
    t_ramp_down();
    t_idle();
    t_ramp_up();
    t_reverse();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule